// File: doc/BRIEF.md
# Single-Threshold Error Diffusion Halftoner

The block turns one plane of 8-bit continuous-tone image data into binary print dots. It accepts pixels one per clock in raster order and returns one output byte for each input byte. The output byte is 0xFF for a dot and 0x00 for no dot. Each pixel is first corrected by the quantisation error of its neighbours, and only then compared against a fixed threshold. The error that remains after that decision is passed on to the pixels that follow.

The corrected value takes error from two places. One is the pixel just before it on the same line. The others are five pixels of the line above, from one column to the left through three columns to the right. All weights are powers of two, so every term is an arithmetic shift. The error of every pixel is kept in a one-line buffer so that the next line can use it. A start-of-frame marker and a start-of-line marker on the input stream set the position in the image. A width input gives the number of pixels per line, and the edge handling follows that width.

Top module: `err_diff_halftoner`

## Requirements
- R1: Every accepted input pixel produces exactly one output pixel, in input order, with `out_valid` high exactly two clock edges after the edge that accepted the input, so a stream with no gaps is processed at one pixel per clock.
- R2: `out_pix` is 0xFF when the corrected value is greater than 127, and 0x00 when it is 127 or less. For example, a value of 127 on the first pixel of a frame gives 0x00, and a value of 128 gives 0xFF.
- R3: The corrected value for column x is the input pixel plus prev>>>1, plus the five line-above errors at x-1, x, x+1, x+2 and x+3 shifted right arithmetically by 2, 3, 4, 5 and 5 in that order. Every shift rounds toward negative infinity.
- R4: The corrected value saturates to the signed 11-bit range. The stored error is the corrected value minus 255 for a dot, or minus 0 for no dot, saturated to the signed 10-bit range.
- R5: On the first line after `in_sof`, every line-above term is zero.
- R6: Neighbours that fall outside the line contribute zero error. These are the column to the left of x=0 and any column at or beyond `line_width`.
- R7: The error from the previous pixel is taken as zero for the first pixel of every line.
- R8: `line_width` sets the line length that the edge handling uses, for any width from 1 to MAX_W. This includes widths of 4 or less, where one line's last error and the next line's first read meet on the same edge.
- R9: After reset, `out_valid` stays low until a pixel is accepted.
- R10: Clocks on which `in_valid` is low produce no output and do not change the result of later pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_width | input | 11 | Pixels per line (1..MAX_W); change only between frames |
| in_valid | input | 1 | Input pixel present this clock |
| in_sof | input | 1 | First pixel of a frame (also starts a line) |
| in_sol | input | 1 | First pixel of a line |
| in_pix | input | 8 | Continuous-tone input pixel |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 8 | Binary result as 0x00 or 0xFF |

## Verification
Flat planes of 0 and 255 show that the block stays off or on with no error drift. Single-pixel frames at 127 and 128 place the threshold exactly. Mid-grey and ramp planes over several lines exercise every weight and the floor rounding of negative errors. A pattern with a bright last pixel on each line separates a correct reset of the previous-pixel error at the line start from a leaked one. Random data with idle gaps checks that stalls leave the results unchanged. Back-to-back lines of width 2, 3 and 4, and one full-width line, cover the edge masking and the case where the buffer is written and read on the same edge.

// File: rtl/hft_pkg.sv
package hft_pkg;
  localparam int PIX_W   = 8;
  localparam int ERR_W   = PIX_W + 2;
  localparam int WORK_W  = PIX_W + 3;
  localparam int SUM_W   = WORK_W + 1;
  localparam int THRESH  = 2 ** (PIX_W - 1) - 1;
  localparam int LVL_ON  = 2 ** PIX_W - 1;
  localparam int ERR_MAX = 2 ** (ERR_W - 1) - 1;
  localparam int ERR_MIN = -(2 ** (ERR_W - 1));
  localparam int WRK_MAX = 2 ** (WORK_W - 1) - 1;
  localparam int WRK_MIN = -(2 ** (WORK_W - 1));
  localparam int N_NB    = 5;   // line-above taps x-1 .. x+3
  localparam int LOOKAHD = 3;   // read-ahead distance
  typedef logic signed [ERR_W-1:0]  err_t;
  typedef logic signed [WORK_W-1:0] work_t;
  typedef logic signed [SUM_W-1:0]  sum_t;
endpackage

// File: rtl/hft_line_mem.sv
module hft_line_mem
  import hft_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  err_t          wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output err_t          rdata
);
  err_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hft_nbr_window.sv
module hft_nbr_window
  import hft_pkg::*;
#(
  parameter int MAX_W = 1024,
  localparam int XW = $clog2(MAX_W + 1),
  localparam int AW = $clog2(MAX_W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          line_start,
  input  logic          cur_first,
  input  logic [XW-1:0] cur_x,
  input  logic [XW-1:0] width,
  input  logic          wr_en,
  input  logic [XW-1:0] wr_x,
  input  err_t          wr_err,
  output err_t          nb [N_NB]
);
  logic [XW:0]   ahead;
  logic          rd_en;
  logic          ok_q, byp_q;
  err_t          byp_d, rdata, fresh;
  err_t          head [LOOKAHD];
  err_t          head_v [LOOKAHD];
  err_t          win [N_NB-1];
  logic          acc_q, first_q, start_q;

  assign ahead = {1'b0, cur_x} + (XW+1)'(LOOKAHD);
  assign rd_en = acc && !cur_first && (ahead < {1'b0, width});

  hft_line_mem #(.DEPTH(MAX_W)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (AW'(wr_x)),
    .wdata (wr_err),
    .re    (rd_en),
    .raddr (AW'(ahead)),
    .rdata (rdata)
  );

  // same-edge write of the address being read ahead: forward new data
  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q  <= 1'b0;
      byp_q <= 1'b0;
      byp_d <= '0;
    end else if (acc) begin
      ok_q  <= rd_en;
      byp_q <= wr_en && ({1'b0, wr_x} == ahead);
      byp_d <= wr_err;
    end
  end

  assign fresh = !ok_q ? err_t'(0) : (byp_q ? byp_d : rdata);

  generate
    for (genvar k = 0; k < LOOKAHD; k++) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) head[k] <= '0;
        else if (wr_en && wr_x == XW'(k)) head[k] <= wr_err;
      end
      always_comb begin
        if (cur_first || XW'(k) >= width) head_v[k] = '0;
        else if (wr_en && wr_x == XW'(k)) head_v[k] = wr_err;
        else head_v[k] = head[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_NB-1; i++) win[i] <= '0;
    end else if (acc) begin
      if (line_start) begin
        win[0] <= '0;
        for (int i = 1; i < N_NB-1; i++) win[i] <= head_v[i-1];
      end else begin
        for (int i = 0; i < N_NB-2; i++) win[i] <= win[i+1];
        win[N_NB-2] <= fresh;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_NB-1; i++) nb[i] = win[i];
    nb[N_NB-1] = fresh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= 1'b0; first_q <= 1'b0; start_q <= 1'b0;
    end else begin
      acc_q <= acc;
      if (acc) begin
        first_q <= cur_first;
        start_q <= line_start;
      end
    end
  end

  p_first_line_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_q && first_q) |-> (nb[0] == 0 && nb[1] == 0 && nb[2] == 0 && nb[3] == 0 && nb[4] == 0));
  p_left_edge_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_q && start_q) |-> (nb[0] == 0));
endmodule

// File: rtl/hft_core.sv
module hft_core
  import hft_pkg::*;
#(
  parameter int MAX_W = 1024,
  localparam int XW = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             line_start,
  input  logic [XW-1:0]    cur_x,
  input  logic [PIX_W-1:0] pix,
  input  err_t             nb [N_NB],
  output logic             wr_en,
  output logic [XW-1:0]    wr_x,
  output err_t             wr_err,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  logic             s1_valid, s1_start;
  logic [XW-1:0]    s1_x;
  logic [PIX_W-1:0] s1_pix;
  err_t             epp, epp_use, err_new;
  sum_t             total, diff;
  work_t            work;
  logic             dot;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_start <= 1'b0;
      s1_x     <= '0;
      s1_pix   <= '0;
    end else begin
      s1_valid <= acc;
      if (acc) begin
        s1_start <= line_start;
        s1_x     <= cur_x;
        s1_pix   <= pix;
      end
    end
  end

  assign epp_use = s1_start ? err_t'(0) : epp;

  always_comb begin
    total = sum_t'($signed({1'b0, s1_pix}))
          + sum_t'(epp_use >>> 1)
          + sum_t'(nb[0] >>> 2) + sum_t'(nb[1] >>> 3) + sum_t'(nb[2] >>> 4)
          + sum_t'(nb[3] >>> 5) + sum_t'(nb[4] >>> 5);
    if (total > sum_t'(WRK_MAX))      work = work_t'(WRK_MAX);
    else if (total < sum_t'(WRK_MIN)) work = work_t'(WRK_MIN);
    else                              work = work_t'(total);
    dot  = (work > work_t'(THRESH));
    diff = sum_t'(work) - (dot ? sum_t'(LVL_ON) : sum_t'(0));
    if (diff > sum_t'(ERR_MAX))      err_new = err_t'(ERR_MAX);
    else if (diff < sum_t'(ERR_MIN)) err_new = err_t'(ERR_MIN);
    else                             err_new = err_t'(diff);
  end

  // the previous-pixel error loop closes in one cycle
  always_ff @(posedge clk) begin
    if (rst) epp <= '0;
    else if (s1_valid) epp <= err_new;
  end

  assign wr_en  = s1_valid;
  assign wr_x   = s1_x;
  assign wr_err = err_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_pix <= dot ? '1 : '0;
    end
  end

  p_levels_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_pix == '0 || out_pix == '1));
endmodule

// File: rtl/err_diff_halftoner.sv
module err_diff_halftoner
  import hft_pkg::*;
#(
  parameter int MAX_W = 1024,
  localparam int XW = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [XW-1:0]    line_width,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_sol,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  logic          line_start, cur_first, first_line;
  logic [XW-1:0] x_cnt, cur_x;
  logic          wr_en;
  logic [XW-1:0] wr_x;
  err_t          wr_err;
  err_t          nb [N_NB];

  assign line_start = in_sol || in_sof;
  assign cur_x      = line_start ? '0 : x_cnt;
  assign cur_first  = in_sof ? 1'b1 : (in_sol ? 1'b0 : first_line);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_cnt      <= '0;
      first_line <= 1'b1;
    end else if (in_valid) begin
      x_cnt      <= cur_x + XW'(1);
      first_line <= cur_first;
    end
  end

  hft_nbr_window #(.MAX_W(MAX_W)) u_win (
    .clk        (clk),
    .rst        (rst),
    .acc        (in_valid),
    .line_start (line_start),
    .cur_first  (cur_first),
    .cur_x      (cur_x),
    .width      (line_width),
    .wr_en      (wr_en),
    .wr_x       (wr_x),
    .wr_err     (wr_err),
    .nb         (nb)
  );

  hft_core #(.MAX_W(MAX_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .acc        (in_valid),
    .line_start (line_start),
    .cur_x      (cur_x),
    .pix        (in_pix),
    .nb         (nb),
    .wr_en      (wr_en),
    .wr_x       (wr_x),
    .wr_err     (wr_err),
    .out_valid  (out_valid),
    .out_pix    (out_pix)
  );

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
endmodule

// File: tb/err_diff_halftoner_tb.sv
module err_diff_halftoner_tb;
  localparam int CLK_P = 10;
  localparam int MAX_W = 1024;
  localparam int XW = $clog2(MAX_W + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic [XW-1:0] line_width = XW'(8);
  logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
  logic [7:0] in_pix = '0;
  logic out_valid;
  logic [7:0] out_pix;

  err_diff_halftoner #(.MAX_W(MAX_W)) u_dut (
    .clk(clk), .rst(rst), .line_width(line_width), .in_valid(in_valid),
    .in_sof(in_sof), .in_sol(in_sol), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] exp_q[$];
  int         cyc_q[$];
  string      tag_q[$];
  int prev_e [MAX_W];
  int cur_e  [MAX_W];
  int prev_ok = 0, epp = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sat(int v, int lo, int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic int above(int x, int w);
    if (prev_ok == 0 || x < 0 || x >= w) return 0;
    return prev_e[x];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected output", out_pix, -1);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic int ec = cyc_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(out_pix == e, t, out_pix, e);
        check(cyc == ec, "R1 latency", cyc, ec);
      end
    end
  end

  task automatic push_pixel(int x, int y, int w, int p, bit sof, string tag, bit gap);
    int work, e;
    if (gap) begin
      @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0; in_pix = 8'h5A;
    end
    if (x == 0) begin
      if (sof) prev_ok = 0;
      else begin
        prev_ok = 1;
        for (int i = 0; i < w; i++) prev_e[i] = cur_e[i];
      end
    end
    work = p + ((x == 0 ? 0 : epp) >>> 1)
         + (above(x-1, w) >>> 2) + (above(x, w) >>> 3) + (above(x+1, w) >>> 4)
         + (above(x+2, w) >>> 5) + (above(x+3, w) >>> 5);
    work = sat(work, -1024, 1023);
    e = sat(work - ((work > 127) ? 255 : 0), -512, 511);
    epp = e;
    cur_e[x] = e;
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_sol = (x == 0); in_pix = 8'(p);
    exp_q.push_back((work > 127) ? 8'hFF : 8'h00);
    cyc_q.push_back(cyc + 2);
    tag_q.push_back(tag);
  endtask

  function automatic int pattern(int mode, int x, int y, int w);
    case (mode)
      0: return 0;
      1: return 255;
      2: return 127;
      3: return 128;
      4: return 100;
      5: return (x * 11 + y * 7) & 255;
      6: return (x == w - 1) ? 220 : 60;
      default: return $urandom_range(0, 255);
    endcase
  endfunction

  task automatic frame(int w, int lines, int mode, string tag, bit gaps);
    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
    line_width = XW'(w);
    for (int y = 0; y < lines; y++)
      for (int x = 0; x < w; x++)
        push_pixel(x, y, w, pattern(mode, x, y, w), (x == 0 && y == 0), tag,
                   gaps && ($urandom_range(0, 3) == 0));
    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R1 all outputs delivered", exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_P * 150000);
    check(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R9 reset quiet", out_valid, 0);
    end
    frame(8, 3, 0, "R2 flat black", 1'b0);
    frame(8, 2, 1, "R2 flat white", 1'b0);
    frame(1, 1, 2, "R2 threshold 127", 1'b0);
    frame(1, 1, 3, "R2 threshold 128", 1'b0);
    frame(16, 6, 4, "R3 R5 mid grey", 1'b0);
    frame(24, 5, 5, "R3 R6 ramp", 1'b0);
    frame(12, 6, 6, "R7 line-start error", 1'b0);
    frame(37, 8, 7, "R10 R4 random with gaps", 1'b1);
    drain();
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R10 idle no output", out_valid, 0);
    frame(2, 5, 7, "R8 width 2", 1'b0);
    frame(3, 5, 7, "R8 width 3", 1'b0);
    frame(4, 5, 4, "R8 width 4", 1'b0);
    frame(MAX_W, 3, 5, "R8 full width", 1'b0);
    drain();
    summary();
    $finish;
  end
endmodule